// File: doc/BRIEF.md
# TDM Slot Serializer with Per-Channel Enables

This block carries up to four 16-bit audio channels in each direction over one serial data line, using time-division multiplexing. An external bit clock and a frame clock (left-right clock) arrive as inputs. The block runs on a faster system clock, oversamples both, and works from the detected bit-clock edges. A rising frame clock marks the start of a frame. The enabled transmit channels are then shifted out back to back on `sdout`, MSB first. In the same frame, the enabled receive channels are collected from `sdin` into parallel sample registers.

The channels form two timeslots, each holding a left/right pair. Channel index 0 is the left channel of timeslot 0, index 1 is the right channel of timeslot 0, index 2 is the left channel of timeslot 1, and index 3 is the right channel of timeslot 1. Each direction has its own enable bit per channel. Disabled channels take no place on the line, so the enabled channels after them move forward.

The enables and the transmit samples are taken at the start of each frame. A new configuration therefore never splits a frame.

Top module: `tdm_slot_serdes`

## Requirements
- R1: While `rst_n` is low, `sdout` is 0, `rx_strobe` is 0 and all of `rx_samples` is 0. Every channel is treated as disabled until a frame begins with enables set.
- R2: A frame begins at the first bit-clock rising edge at which the frame clock is seen high after having been seen low. In that frame, the enabled transmit channels are sent in rising index order (0, 1, 2, 3), skipping disabled ones. Each channel takes 16 consecutive bits. Channel c is taken from `tx_samples[16c+15:16c]` and sent MSB first.
- R3: The first data bit appears after the bit-clock falling edge that follows the frame-start rising edge. `sdout` changes only after a bit-clock falling edge.
- R4: `sdin` is sampled on bit-clock rising edges. The k-th group of 16 bits of the frame (counting from 0) belongs to the k-th enabled receive channel in rising index order. A complete word for channel c lands in `rx_samples[16c+15:16c]`.
- R5: When no transmit channel is enabled, `sdout` stays 0. When no receive channel is enabled, `rx_strobe` stays 0.
- R6: Each enabled receive channel raises its own bit of `rx_strobe` for exactly one system clock per frame, after its last bit is captured. At most one strobe bit is high at a time.
- R7: `tx_enable`, `rx_enable` and `tx_samples` are taken at frame start. Changes made during a frame first take effect in the next frame.
- R8: Bit positions beyond the last enabled transmit channel drive `sdout` low. `sdin` data at positions beyond the last enabled receive channel is ignored. A disabled receive channel keeps its previous `rx_samples` word.
- R9: After reset, a frame clock that is already high does not start a frame. The first frame needs a low-to-high transition of the frame clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bit and frame clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock |
| lrclk_in | input | 1 | Frame clock; a rising edge starts a frame |
| sdin | input | 1 | Serial receive data |
| tx_enable | input | 4 | Per-channel transmit enables, index 0 to 3 |
| rx_enable | input | 4 | Per-channel receive enables, index 0 to 3 |
| tx_samples | input | 64 | Transmit words, channel c at bits 16c+15:16c |
| sdout | output | 1 | Serial transmit data |
| rx_samples | output | 64 | Received words, channel c at bits 16c+15:16c |
| rx_strobe | output | 4 | One-cycle pulse per channel when its word is complete |

## Verification
The hardest situations to reach from the ports are two. The first is a configuration change that arrives in the middle of a frame. The second is a frame clock that is already high when reset is released. For the first, the bench rewrites the transmit enables, the receive enables and a transmit word twenty bit periods into a frame. It checks that the stream and the received words in that frame still follow the values present at frame start, and that the next frame follows the new ones. For the second, the bench holds the frame clock high through and after reset while sending all-ones data. It confirms that the line stays low and no word arrives until a real rising edge of the frame clock. Throughout, unused receive positions carry ones, so that any stray capture into a disabled channel shows up.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  // Widest enable vector the helper functions accept.
  localparam int unsigned MAX_CH = 8;

  // Number of enabled channels.
  function automatic int unsigned count_en(input logic [MAX_CH-1:0] en);
    int unsigned n;
    n = 0;
    for (int unsigned i = 0; i < MAX_CH; i++) begin
      if (en[i]) n = n + 1;
    end
    return n;
  endfunction

  // Channel index occupying line position pos; MAX_CH when none does.
  function automatic int unsigned pick_chan(input logic [MAX_CH-1:0] en,
                                            input int unsigned pos);
    int unsigned seen;
    int unsigned ch;
    seen = 0;
    ch   = MAX_CH;
    for (int unsigned i = 0; i < MAX_CH; i++) begin
      if (en[i]) begin
        if (seen == pos && ch == MAX_CH) ch = i;
        seen = seen + 1;
      end
    end
    return ch;
  endfunction

  // Line position of a frame bit count.
  function automatic int unsigned slot_of(input int unsigned cnt, input int unsigned w);
    return cnt / w;
  endfunction

  // Bit offset within its word of a frame bit count, counted from the MSB side.
  function automatic int unsigned bit_of(input int unsigned cnt, input int unsigned w);
    return cnt % w;
  endfunction

endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic lrclk_in,
  input  logic din_in,
  output logic bit_rise,
  output logic bit_fall,
  output logic lr_lvl,
  output logic din_lvl
);

  // One pipeline for all three lines keeps them aligned to the same sample.
  logic [2:0] pipe_q [STAGES+1];
  logic [2:0] cur;
  logic [2:0] old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) pipe_q[i] <= '0;
    end else begin
      pipe_q[0] <= {bclk_in, lrclk_in, din_in};
      for (int i = 1; i <= STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign cur      = pipe_q[STAGES-1];
  assign old      = pipe_q[STAGES];
  assign bit_rise = cur[2] & ~old[2];
  assign bit_fall = ~cur[2] & old[2];
  assign lr_lvl   = cur[1];
  assign din_lvl  = cur[0];

endmodule

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned CNT_W    = $clog2(NUM_CH*SAMPLE_W+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_rise,
  input  logic              lr_lvl,
  input  logic [NUM_CH-1:0] tx_enable,
  input  logic [NUM_CH-1:0] rx_enable,
  output logic              frame_start,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [NUM_CH-1:0] tx_en_q,
  output logic [NUM_CH-1:0] rx_en_q
);

  localparam int unsigned TOTAL = NUM_CH * SAMPLE_W;

  logic lr_prev_q;

  // Reset treats the frame clock as already high, so only a real rise starts a frame.
  assign frame_start = bit_rise && lr_lvl && !lr_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_prev_q <= 1'b1;
      bit_cnt   <= CNT_W'(TOTAL);
      tx_en_q   <= '0;
      rx_en_q   <= '0;
    end else if (bit_rise) begin
      lr_prev_q <= lr_lvl;
      if (frame_start) begin
        bit_cnt <= '0;
        tx_en_q <= tx_enable;
        rx_en_q <= rx_enable;
      end else if (bit_cnt != CNT_W'(TOTAL)) begin
        bit_cnt <= bit_cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/tdm_tx_shift.sv
module tdm_tx_shift
  import tdm_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned CNT_W    = $clog2(NUM_CH*SAMPLE_W+1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_start,
  input  logic                       bit_fall,
  input  logic [CNT_W-1:0]           bit_cnt,
  input  logic [NUM_CH-1:0]          tx_en_q,
  input  logic [NUM_CH*SAMPLE_W-1:0] tx_samples,
  output logic                       slot_live,
  output logic                       sdout
);

  localparam int unsigned TOTAL = NUM_CH * SAMPLE_W;
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned BIT_W = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] word_q [NUM_CH];
  logic [MAX_CH-1:0]   en_ext;
  int unsigned         pos_i;
  int unsigned         bit_i;
  int unsigned         ch_i;
  logic [CH_W-1:0]     ch_sel;
  logic [BIT_W-1:0]    bit_sel;
  logic                next_bit;

  always_comb begin
    en_ext             = '0;
    en_ext[NUM_CH-1:0] = tx_en_q;
    pos_i     = slot_of(32'(bit_cnt), SAMPLE_W);
    bit_i     = bit_of(32'(bit_cnt), SAMPLE_W);
    ch_i      = pick_chan(en_ext, pos_i);
    slot_live = (32'(bit_cnt) < TOTAL) && (pos_i < count_en(en_ext));
    ch_sel    = CH_W'(ch_i);
    bit_sel   = BIT_W'(SAMPLE_W - 1 - bit_i);
    next_bit  = slot_live && word_q[ch_sel][bit_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdout <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) word_q[i] <= '0;
    end else begin
      if (frame_start) begin
        for (int i = 0; i < NUM_CH; i++) word_q[i] <= tx_samples[i*SAMPLE_W +: SAMPLE_W];
      end
      if (bit_fall) sdout <= next_bit;
    end
  end

endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture
  import tdm_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned CNT_W    = $clog2(NUM_CH*SAMPLE_W+1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_rise,
  input  logic                       din_lvl,
  input  logic [CNT_W-1:0]           bit_cnt,
  input  logic [NUM_CH-1:0]          rx_en_q,
  output logic [NUM_CH*SAMPLE_W-1:0] rx_samples,
  output logic [NUM_CH-1:0]          rx_strobe
);

  localparam int unsigned TOTAL = NUM_CH * SAMPLE_W;
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [SAMPLE_W-1:0] store_q [NUM_CH];
  logic [SAMPLE_W-2:0] shift_q;
  logic [MAX_CH-1:0]   en_ext;
  int unsigned         pos_i;
  int unsigned         bit_i;
  int unsigned         ch_i;
  logic [CH_W-1:0]     ch_sel;
  logic                live;
  logic                last_bit;

  always_comb begin
    en_ext             = '0;
    en_ext[NUM_CH-1:0] = rx_en_q;
    pos_i    = slot_of(32'(bit_cnt), SAMPLE_W);
    bit_i    = bit_of(32'(bit_cnt), SAMPLE_W);
    ch_i     = pick_chan(en_ext, pos_i);
    live     = (32'(bit_cnt) < TOTAL) && (pos_i < count_en(en_ext));
    ch_sel   = CH_W'(ch_i);
    last_bit = (bit_i == SAMPLE_W - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q   <= '0;
      rx_strobe <= '0;
      for (int i = 0; i < NUM_CH; i++) store_q[i] <= '0;
    end else begin
      rx_strobe <= '0;
      if (bit_rise && live) begin
        shift_q <= {shift_q[SAMPLE_W-3:0], din_lvl};
        if (last_bit) begin
          store_q[ch_sel]   <= {shift_q, din_lvl};
          rx_strobe[ch_sel] <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
    assign rx_samples[g*SAMPLE_W +: SAMPLE_W] = store_q[g];
  end

endmodule

// File: rtl/tdm_slot_serdes.sv
module tdm_slot_serdes #(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned SAMPLE_W    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bclk_in,
  input  logic                       lrclk_in,
  input  logic                       sdin,
  input  logic [NUM_CH-1:0]          tx_enable,
  input  logic [NUM_CH-1:0]          rx_enable,
  input  logic [NUM_CH*SAMPLE_W-1:0] tx_samples,
  output logic                       sdout,
  output logic [NUM_CH*SAMPLE_W-1:0] rx_samples,
  output logic [NUM_CH-1:0]          rx_strobe
);

  localparam int unsigned CNT_W = $clog2(NUM_CH*SAMPLE_W+1);

  // Named internal events, visible to the bound checker.
  logic              bit_rise;
  logic              bit_fall;
  logic              lr_lvl;
  logic              din_lvl;
  logic              frame_start;
  logic [CNT_W-1:0]  bit_cnt;
  logic [NUM_CH-1:0] tx_en_q;
  logic [NUM_CH-1:0] rx_en_q;
  logic              tx_slot_live;

  tdm_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .bclk_in(bclk_in), .lrclk_in(lrclk_in), .din_in(sdin),
    .bit_rise(bit_rise), .bit_fall(bit_fall),
    .lr_lvl(lr_lvl), .din_lvl(din_lvl)
  );

  tdm_frame_ctrl #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) frame_i (
    .clk(clk), .rst_n(rst_n),
    .bit_rise(bit_rise), .lr_lvl(lr_lvl),
    .tx_enable(tx_enable), .rx_enable(rx_enable),
    .frame_start(frame_start), .bit_cnt(bit_cnt),
    .tx_en_q(tx_en_q), .rx_en_q(rx_en_q)
  );

  tdm_tx_shift #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) tx_i (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .bit_fall(bit_fall),
    .bit_cnt(bit_cnt), .tx_en_q(tx_en_q), .tx_samples(tx_samples),
    .slot_live(tx_slot_live), .sdout(sdout)
  );

  tdm_rx_capture #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) rx_i (
    .clk(clk), .rst_n(rst_n),
    .bit_rise(bit_rise), .din_lvl(din_lvl),
    .bit_cnt(bit_cnt), .rx_en_q(rx_en_q),
    .rx_samples(rx_samples), .rx_strobe(rx_strobe)
  );

endmodule

// File: rtl/tdm_slot_serdes_chk.sv
module tdm_slot_serdes_chk #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned CNT_W    = $clog2(NUM_CH*SAMPLE_W+1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_rise,
  input logic              bit_fall,
  input logic              frame_start,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [NUM_CH-1:0] tx_en_q,
  input logic [NUM_CH-1:0] rx_en_q,
  input logic              tx_slot_live,
  input logic              sdout,
  input logic [NUM_CH-1:0] rx_strobe
);

  a_r2_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (bit_cnt == '0));

  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(NUM_CH*SAMPLE_W));

  a_r3_sdout_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_fall |=> $stable(sdout));

  a_r5_line_low_outside_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_fall && !tx_slot_live) |=> !sdout);

  a_r5_no_strobe_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en_q == '0) |=> (rx_strobe == '0));

  a_r6_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_strobe));

  a_r6_strobe_follows_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe != '0) |-> $past(bit_rise));

  a_r8_strobe_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe != '0) |-> ((rx_strobe & ~$past(rx_en_q)) == '0));

  a_r7_enables_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(tx_en_q) && $stable(rx_en_q)));

endmodule

bind tdm_slot_serdes tdm_slot_serdes_chk #(
  .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .bit_rise(bit_rise), .bit_fall(bit_fall),
  .frame_start(frame_start), .bit_cnt(bit_cnt),
  .tx_en_q(tx_en_q), .rx_en_q(rx_en_q),
  .tx_slot_live(tx_slot_live), .sdout(sdout),
  .rx_strobe(rx_strobe)
);

// File: tb/tdm_slot_serdes_tb_top.sv
module tdm_slot_serdes_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk;
  logic        lrclk;
  logic        sdin_b;
  logic [3:0]  tx_en_r;
  logic [3:0]  rx_en_r;
  logic [63:0] tx_words;
  logic [63:0] rx_words_r;
  logic        sdout_w;
  logic [63:0] rx_samples_w;
  logic [3:0]  rx_strobe_w;

  int checks = 0;
  int fails  = 0;
  int vtot [4];
  logic [15:0] rx_model [4];

  // Values applied mid-frame by run_frame.
  logic [3:0]  nxt_tx_en;
  logic [3:0]  nxt_rx_en;
  logic [63:0] nxt_tx_words;

  always #4 clk = ~clk;

  tdm_slot_serdes dut_i (
    .clk(clk), .rst_n(rst_n),
    .bclk_in(bclk), .lrclk_in(lrclk), .sdin(sdin_b),
    .tx_enable(tx_en_r), .rx_enable(rx_en_r), .tx_samples(tx_words),
    .sdout(sdout_w), .rx_samples(rx_samples_w), .rx_strobe(rx_strobe_w)
  );

  initial for (int c = 0; c < 4; c++) vtot[c] = 0;

  always @(negedge clk) begin
    for (int c = 0; c < 4; c++) if (rx_strobe_w[c] === 1'b1) vtot[c] = vtot[c] + 1;
  end

  // {tx_enable, rx_enable, seed}
  localparam logic [23:0] VEC [6] = '{
    {4'b1111, 4'b1111, 16'hA5C3},
    {4'b0101, 4'b1010, 16'h1E2D},
    {4'b1000, 4'b0001, 16'hFFFF},
    {4'b0110, 4'b0110, 16'h8001},
    {4'b0000, 4'b0000, 16'h3C3C},
    {4'b1011, 4'b1100, 16'h7E11}
  };

  function automatic logic [15:0] tx_word(input logic [15:0] s, input int c);
    return {s[7:0], s[15:8]} ^ (16'h1357 << c) ^ 16'(c * 16'h0101);
  endfunction

  function automatic logic [15:0] rx_word(input logic [15:0] s, input int c);
    return (~s ^ (16'h2468 >> c)) + 16'(c * 3);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One bit period: 4 system clocks low, 4 high; data changes at the fall.
  task automatic bit_period(input logic lr, input logic din, output logic seen);
    @(negedge clk);
    bclk = 1'b0; lrclk = lr; sdin_b = din;
    repeat (3) @(negedge clk);
    seen = sdout_w;
    @(negedge clk);
    bclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n, input logic lr);
    logic s;
    for (int i = 0; i < n; i++) bit_period(lr, 1'b0, s);
  endtask

  // 80-period frame: frame clock high for 40, low for 40. Data bit d in period d+1.
  task automatic run_frame(input int mid_at);
    logic [3:0]  ft = tx_en_r;
    logic [3:0]  fr = rx_en_r;
    logic [63:0] fw = tx_words;
    logic [63:0] rw = rx_words_r;
    int tord [4];
    int rord [4];
    int nt = 0;
    int nr = 0;
    int v0 [4];
    logic [78:0] exp_s = '0;
    logic [78:0] act_s = '0;
    logic seen;
    logic din;
    for (int c = 0; c < 4; c++) begin
      tord[c] = 0; rord[c] = 0; v0[c] = vtot[c];
    end
    for (int c = 0; c < 4; c++) if (ft[c]) begin tord[nt] = c; nt++; end
    for (int c = 0; c < 4; c++) if (fr[c]) begin rord[nr] = c; nr++; end
    for (int i = 0; i < 80; i++) begin
      int d = i - 1;
      din = 1'b1;
      if (d >= 0 && d < 64 && (d / 16) < nr) din = rw[rord[d/16]*16 + 15 - d%16];
      bit_period(i < 40, din, seen);
      if (d >= 0) begin
        act_s[d] = seen;
        exp_s[d] = (d < 64 && (d / 16) < nt) ? fw[tord[d/16]*16 + 15 - d%16] : 1'b0;
      end
      if (i == mid_at) begin
        tx_en_r = nxt_tx_en; rx_en_r = nxt_rx_en; tx_words = nxt_tx_words;
      end
    end
    // R2 order and MSB-first stream, R3 first-bit timing, R8 low tail, R5 when none
    check(act_s === exp_s, (nt == 0) ? "R5 sdout idle" : "R2 R3 R8 sdout stream",
          128'(act_s), 128'(exp_s));
    for (int c = 0; c < 4; c++) begin
      if (fr[c]) rx_model[c] = rw[c*16 +: 16];
      // R4 capture into enabled channels, R8 disabled channels keep their word
      check(rx_samples_w[c*16 +: 16] === rx_model[c], fr[c] ? "R4 rx word" : "R8 rx word held",
            128'(rx_samples_w[c*16 +: 16]), 128'(rx_model[c]));
      // R6 one single-cycle strobe per enabled channel, R5 none otherwise
      check((vtot[c] - v0[c]) == (fr[c] ? 1 : 0), (fr == 0) ? "R5 strobe count" : "R6 strobe count",
            128'(vtot[c] - v0[c]), 128'(fr[c] ? 1 : 0));
    end
  endtask

  task automatic load_vec(input logic [23:0] v);
    tx_en_r = v[23:20];
    rx_en_r = v[19:16];
    for (int c = 0; c < 4; c++) begin
      tx_words[c*16 +: 16]   = tx_word(v[15:0], c);
      rx_words_r[c*16 +: 16] = rx_word(v[15:0], c);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic s;
    logic any_hi;
    int v0 [4];
    rst_n = 1'b0; bclk = 1'b0; lrclk = 1'b0; sdin_b = 1'b0;
    tx_en_r = '0; rx_en_r = '0; tx_words = '0; rx_words_r = '0;
    for (int c = 0; c < 4; c++) rx_model[c] = '0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(sdout_w === 1'b0, "R1 sdout in reset", 128'(sdout_w), 128'(0));
    check(rx_strobe_w === 4'b0, "R1 strobe in reset", 128'(rx_strobe_w), 128'(0));
    check(rx_samples_w === 64'b0, "R1 rx words in reset", 128'(rx_samples_w), 128'(0));
    rst_n = 1'b1;
    idle(4, 1'b0);

    // Vector table walk
    for (int k = 0; k < 6; k++) begin
      load_vec(VEC[k]);
      run_frame(-1);
    end

    // R7: enables and samples changed mid-frame take effect next frame
    load_vec({4'b1111, 4'b1111, 16'h5AA5});
    nxt_tx_en    = 4'b0001;
    nxt_rx_en    = 4'b0010;
    nxt_tx_words = ~tx_words;
    run_frame(20);
    rx_words_r = {rx_words_r[31:0], rx_words_r[63:32]};
    run_frame(-1);

    // R9: frame clock high across reset must not start a frame
    rst_n = 1'b0; lrclk = 1'b1; bclk = 1'b0; sdin_b = 1'b1;
    tx_en_r = 4'b1111; rx_en_r = 4'b1111; tx_words = {4{16'hFFFF}};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin rx_model[c] = '0; v0[c] = vtot[c]; end
    any_hi = 1'b0;
    for (int i = 0; i < 80; i++) begin
      bit_period(1'b1, 1'b1, s);
      any_hi = any_hi | s;
    end
    check(any_hi === 1'b0, "R9 sdout without frame", 128'(any_hi), 128'(0));
    check((vtot[0] + vtot[1] + vtot[2] + vtot[3]) == (v0[0] + v0[1] + v0[2] + v0[3]),
          "R9 strobes without frame",
          128'((vtot[0] + vtot[1] + vtot[2] + vtot[3]) - (v0[0] + v0[1] + v0[2] + v0[3])), 128'(0));
    check(rx_samples_w === 64'b0, "R9 rx words without frame", 128'(rx_samples_w), 128'(0));
    idle(40, 1'b0);
    load_vec({4'b1001, 4'b0110, 16'h0F0F});
    run_frame(-1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule